// File: doc/BRIEF.md
# Soft Interrupt Priority Controller

This block keeps a software-interrupt pending register beside a processor core and folds it together with a set of external interrupt-level request lines. From the combined vector it picks the highest requested level and presents one interrupt request to the core. The request is a trap code and a level flag. The trap code is a fixed external-interrupt base with the winning level in its low bits.

Privileged software changes the pending register through a small register port. One address sets bits, one clears bits and one overwrites the register. The value used by each operation is the XOR of two operands. A timer-match event posts the timer soft bit, which is bit 0. That bit is routed to request level 14. A non-interrupt trap that the core already has pending freezes the trap code until it is gone. The block also produces a wake pulse whenever an external line rises, so a halted core can resume.

Top module: `softirq_prio_ctrl`

## Requirements
- R1: A supervisor write to address 0x14 ORs (reg_opa ^ reg_opb) into the soft register at the next clock edge.
- R2: A supervisor write to address 0x15 clears the bits set in (reg_opa ^ reg_opb) at the next clock edge. All other bits are kept.
- R3: A supervisor write to address 0x16 replaces the soft register with (reg_opa ^ reg_opb). A read of address 0x16 returns the current 32-bit register value combinationally, in either mode. A read of any other address returns zero.
- R4: A write to 0x14, 0x15 or 0x16 with supervisor low raises illegal_op in that same cycle and leaves the register unchanged. A read of 0x14 or 0x15 raises illegal_op in either mode.
- R5: timer_match sets soft bit 0 at the next edge. This is applied after any write in the same cycle, so a same-cycle clear of bit 0 loses to it.
- R6: Each soft bit 1 to 15 requests its own level. Soft bit 0 requests level 14. Soft bits 16 to 31 request nothing. ext_lvl bit n requests level n.
- R7: The highest requested level L among 15 down to 1 wins. trap_code becomes 0x40 | L and irq_req becomes 1 at the first clock edge after the request vector shows it. For a soft write this is the second edge after the write is presented.
- R8: Level 0 never causes a request. If only level 0 is requested while a code is pending, that code is held unchanged.
- R9: While other_trap_pend is 1, trap_code and irq_req hold their value. Neither an update nor a clear takes place.
- R10: irq_new pulses for one cycle, together with trap_code, exactly when trap_code takes a new nonzero value. It stays low when the winner does not change.
- R11: When no level 0 to 15 is requested and other_trap_pend is 0, trap_code clears to zero and irq_req to 0 at the next edge.
- R12: wake is 1 for the one cycle after an edge at which some ext_lvl bit was 1 and had been 0 at the previous edge.
- R13: During and after reset the soft register, trap_code, irq_req, irq_new and wake are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_opa | input | 32 | First write operand |
| reg_opb | input | 32 | Second write operand, XORed with the first |
| supervisor | input | 1 | Access is privileged |
| reg_rd_data | output | 32 | Read data, combinational |
| illegal_op | output | 1 | Access is not allowed, combinational |
| timer_match | input | 1 | Timer compare event |
| ext_lvl | input | 16 | External level request lines |
| other_trap_pend | input | 1 | Core holds a non-interrupt trap |
| trap_code | output | 8 | Current interrupt trap code, zero when none |
| irq_req | output | 1 | Interrupt request level |
| irq_new | output | 1 | One-cycle pulse when a new code is raised |
| wake | output | 1 | Pulse after a rising external line |

## Verification
The bench builds the block with its default parameters: 16 levels, a 32-bit soft register, level 14 for the timer bit and a 0x40 trap base. At this size every single level and every ordered pair of external levels can be swept. All 32 soft bits can also be swept one at a time, which makes the relocation of bit 0 and the dead upper bits directly visible. The hold cases get dedicated sequences: a level-0-only request, a blocking non-interrupt trap, and a timer event that collides with a clear.

// File: rtl/softirq_pkg.sv
package softirq_pkg;
   typedef enum logic [1:0] {
      SOP_NONE = 2'd0,
      SOP_SET  = 2'd1,
      SOP_CLR  = 2'd2,
      SOP_WR   = 2'd3
   } soft_op_e;

   function automatic logic [31:0] soft_apply(input soft_op_e op,
                                              input logic [31:0] cur,
                                              input logic [31:0] val);
      case (op)
         SOP_SET: soft_apply = cur | val;
         SOP_CLR: soft_apply = cur & ~val;
         SOP_WR:  soft_apply = val;
         default: soft_apply = cur;
      endcase
   endfunction
endpackage

// File: rtl/softirq_reg.sv
module softirq_reg
   import softirq_pkg::*;
#(
   parameter int SOFT_W   = 32,
   parameter int NUM_LVL  = 16,
   parameter int ADDR_W   = 6,
   parameter int ADDR_SET = 'h14,
   parameter int ADDR_CLR = 'h15,
   parameter int ADDR_WR  = 'h16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SOFT_W-1:0] opa,
   input  logic [SOFT_W-1:0] opb,
   input  logic              supervisor,
   input  logic              timer_match,
   output logic [SOFT_W-1:0] rd_data,
   output logic              illegal,
   output logic [NUM_LVL-1:0] soft_lvl
);
   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(ADDR_SET);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADDR_CLR);
   localparam logic [ADDR_W-1:0] A_WR  = ADDR_W'(ADDR_WR);

   logic [SOFT_W-1:0] soft_q, soft_d;
   soft_op_e          op;
   logic              wr_hit, rd_wo;
   logic [31:0]       applied;

   always_comb begin
      wr_hit = wr_en && (addr == A_SET || addr == A_CLR || addr == A_WR);
      rd_wo  = rd_en && (addr == A_SET || addr == A_CLR);
      op     = SOP_NONE;
      if (wr_hit && supervisor) begin
         if (addr == A_SET)      op = SOP_SET;
         else if (addr == A_CLR) op = SOP_CLR;
         else                    op = SOP_WR;
      end
      illegal = (wr_hit && !supervisor) || rd_wo;
      applied = soft_apply(op, 32'(soft_q), 32'(opa ^ opb));
      soft_d  = SOFT_W'(applied);
      if (timer_match) soft_d[0] = 1'b1;
      rd_data = (rd_en && addr == A_WR) ? soft_q : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_q <= '0;
      else        soft_q <= soft_d;
   end

   assign soft_lvl = soft_q[NUM_LVL-1:0];
endmodule

// File: rtl/softirq_merge.sv
module softirq_merge #(
   parameter int NUM_LVL   = 16,
   parameter int TIMER_LVL = 14
) (
   input  logic [NUM_LVL-1:0] ext_lvl,
   input  logic [NUM_LVL-1:0] soft_lvl,
   output logic [NUM_LVL-1:0] merged
);
   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      if (l == 0) begin : g_zero
         assign merged[l] = ext_lvl[l];
      end else if (l == TIMER_LVL) begin : g_timer
         assign merged[l] = ext_lvl[l] | soft_lvl[l] | soft_lvl[0];
      end else begin : g_plain
         assign merged[l] = ext_lvl[l] | soft_lvl[l];
      end
   end
endmodule

// File: rtl/softirq_prio.sv
module softirq_prio #(
   parameter int NUM_LVL = 16,
   parameter int LVL_W   = $clog2(NUM_LVL)
) (
   input  logic [NUM_LVL-1:0] vec,
   output logic               hit,
   output logic [LVL_W-1:0]   win_lvl
);
   always_comb begin
      hit     = 1'b0;
      win_lvl = '0;
      for (int i = 1; i < NUM_LVL; i++) begin
         if (vec[i]) begin
            hit     = 1'b1;
            win_lvl = LVL_W'(i);
         end
      end
   end
endmodule

// File: rtl/softirq_trap.sv
module softirq_trap #(
   parameter int             TT_W      = 8,
   parameter int             LVL_W     = 4,
   parameter logic [TT_W-1:0] TRAP_BASE = 8'h40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             other_trap_pend,
   input  logic             any_req,
   input  logic             hit,
   input  logic [LVL_W-1:0] win_lvl,
   output logic [TT_W-1:0]  trap_code,
   output logic             irq_req,
   output logic             irq_new
);
   localparam int HI_W = TT_W - LVL_W;
   localparam logic [HI_W-1:0] BASE_HI = TRAP_BASE[TT_W-1:LVL_W];

   logic [TT_W-1:0] code_q, code_d, cand;
   logic            ext_pend, may_upd, new_d;

   always_comb begin
      ext_pend = (code_q[TT_W-1:LVL_W] == BASE_HI);
      may_upd  = !other_trap_pend && (code_q == '0 || ext_pend);
      cand     = TRAP_BASE | {{HI_W{1'b0}}, win_lvl};
      code_d   = code_q;
      new_d    = 1'b0;
      if (may_upd && hit) begin
         code_d = cand;
         new_d  = (cand != code_q);
      end else if (!other_trap_pend && !any_req && ext_pend) begin
         code_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         irq_req <= 1'b0;
         irq_new <= 1'b0;
      end else begin
         code_q  <= code_d;
         irq_req <= (code_d != '0);
         irq_new <= new_d;
      end
   end

   assign trap_code = code_q;
endmodule

// File: rtl/softirq_prio_ctrl.sv
module softirq_prio_ctrl #(
   parameter int             SOFT_W    = 32,
   parameter int             NUM_LVL   = 16,
   parameter int             TIMER_LVL = 14,
   parameter int             ADDR_W    = 6,
   parameter int             TT_W      = 8,
   parameter logic [TT_W-1:0] TRAP_BASE = 8'h40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_en,
   input  logic               reg_rd_en,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [SOFT_W-1:0]  reg_opa,
   input  logic [SOFT_W-1:0]  reg_opb,
   input  logic               supervisor,
   output logic [SOFT_W-1:0]  reg_rd_data,
   output logic               illegal_op,
   input  logic               timer_match,
   input  logic [NUM_LVL-1:0] ext_lvl,
   input  logic               other_trap_pend,
   output logic [TT_W-1:0]    trap_code,
   output logic               irq_req,
   output logic               irq_new,
   output logic               wake
);
   localparam int LVL_W = $clog2(NUM_LVL);

   if (SOFT_W < NUM_LVL || SOFT_W > 32) begin : g_bad_soft
      $error("SOFT_W must lie between NUM_LVL and 32");
   end
   if (NUM_LVL != (1 << LVL_W) || NUM_LVL < 2) begin : g_bad_lvl
      $error("NUM_LVL must be a power of two");
   end
   if (TIMER_LVL < 1 || TIMER_LVL >= NUM_LVL) begin : g_bad_tmr
      $error("TIMER_LVL out of range");
   end
   if (TT_W <= LVL_W || TRAP_BASE[LVL_W-1:0] != '0 || TRAP_BASE == '0) begin : g_bad_base
      $error("TRAP_BASE must be nonzero with clear level bits");
   end

   logic [NUM_LVL-1:0] soft_lvl, merged, ext_q;
   logic               hit, wake_q;
   logic [LVL_W-1:0]   win_lvl;

   softirq_reg #(
      .SOFT_W(SOFT_W), .NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
      .addr(reg_addr), .opa(reg_opa), .opb(reg_opb),
      .supervisor(supervisor), .timer_match(timer_match),
      .rd_data(reg_rd_data), .illegal(illegal_op), .soft_lvl(soft_lvl)
   );

   softirq_merge #(.NUM_LVL(NUM_LVL), .TIMER_LVL(TIMER_LVL)) u_merge (
      .ext_lvl(ext_lvl), .soft_lvl(soft_lvl), .merged(merged)
   );

   softirq_prio #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_prio (
      .vec(merged), .hit(hit), .win_lvl(win_lvl)
   );

   softirq_trap #(.TT_W(TT_W), .LVL_W(LVL_W), .TRAP_BASE(TRAP_BASE)) u_trap (
      .clk(clk), .rst_n(rst_n), .other_trap_pend(other_trap_pend),
      .any_req(|merged), .hit(hit), .win_lvl(win_lvl),
      .trap_code(trap_code), .irq_req(irq_req), .irq_new(irq_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q  <= '0;
         wake_q <= 1'b0;
      end else begin
         ext_q  <= ext_lvl;
         wake_q <= |(ext_lvl & ~ext_q);
      end
   end

   assign wake = wake_q;
endmodule

// File: rtl/softirq_prio_ctrl_chk.sv
module softirq_prio_ctrl_chk #(
   parameter int             NUM_LVL   = 16,
   parameter int             TT_W      = 8,
   parameter logic [TT_W-1:0] TRAP_BASE = 8'h40
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr_en,
   input logic               supervisor,
   input logic               timer_match,
   input logic               other_trap_pend,
   input logic [NUM_LVL-1:0] ext_lvl,
   input logic [NUM_LVL-1:0] soft_lvl,
   input logic [TT_W-1:0]    trap_code,
   input logic               irq_req,
   input logic               irq_new
);
   localparam int LVL_W = $clog2(NUM_LVL);

   p_user_wr_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !supervisor && !timer_match) |=> $stable(soft_lvl));

   p_timer_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      timer_match |=> soft_lvl[0]);

   p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (trap_code[TT_W-1:LVL_W] == TRAP_BASE[TT_W-1:LVL_W]
                   && trap_code[LVL_W-1:0] != '0));

   p_block_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
      other_trap_pend |=> ($stable(trap_code) && $stable(irq_req)));

   p_new_changes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_new |-> (trap_code != $past(trap_code) && irq_req));

   p_retract_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_lvl == '0 && soft_lvl == '0 && !other_trap_pend)
         |=> (trap_code == '0 && !irq_req));
endmodule

bind softirq_prio_ctrl softirq_prio_ctrl_chk #(
   .NUM_LVL(NUM_LVL), .TT_W(TT_W), .TRAP_BASE(TRAP_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .supervisor(supervisor),
   .timer_match(timer_match), .other_trap_pend(other_trap_pend),
   .ext_lvl(ext_lvl), .soft_lvl(soft_lvl), .trap_code(trap_code),
   .irq_req(irq_req), .irq_new(irq_new)
);

// File: tb/softirq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module softirq_prio_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 0, reg_rd_en = 0, supervisor = 0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_opa = '0, reg_opb = '0;
   logic [31:0] reg_rd_data;
   logic        illegal_op, timer_match = 0, other_trap_pend = 0;
   logic [15:0] ext_lvl = '0;
   logic [7:0]  trap_code;
   logic        irq_req, irq_new, wake;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   softirq_prio_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_addr(reg_addr), .reg_opa(reg_opa), .reg_opb(reg_opb),
      .supervisor(supervisor), .reg_rd_data(reg_rd_data),
      .illegal_op(illegal_op), .timer_match(timer_match), .ext_lvl(ext_lvl),
      .other_trap_pend(other_trap_pend), .trap_code(trap_code),
      .irq_req(irq_req), .irq_new(irq_new), .wake(wake)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   function automatic logic [7:0] exp_code(input logic [15:0] e, input logic [31:0] s);
      logic [15:0] m;
      m = e | (s[15:0] & 16'hFFFE) | (s[0] ? 16'h4000 : 16'h0);
      exp_code = 8'h00;
      for (int i = 15; i >= 1; i--) begin
         if (m[i] && exp_code == 8'h00) exp_code = 8'h40 | 8'(i);
      end
   endfunction

   // drive a write at a negedge; returns at the following negedge
   task automatic sw_write(input logic [5:0] a, input logic [31:0] x,
                           input logic [31:0] y, input logic sup, output logic ill);
      @(negedge clk);
      reg_wr_en = 1; reg_addr = a; reg_opa = x; reg_opb = y; supervisor = sup;
      #1 ill = illegal_op;
      @(negedge clk);
      reg_wr_en = 0; supervisor = 0;
   endtask

   task automatic sw_read(input logic [5:0] a, output logic [31:0] d, output logic ill);
      reg_rd_en = 1; reg_addr = a;
      #1 d = reg_rd_data; ill = illegal_op;
      reg_rd_en = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic        ill;
      logic [31:0] d;
      logic [7:0]  e;

      // R13 reset
      repeat (3) @(negedge clk);
      sw_read(6'h16, d, ill);
      chk(d == 0, "R13 soft reg at reset", d, 0);
      chk(trap_code == 0 && !irq_req && !irq_new && !wake, "R13 outputs at reset",
          {trap_code, irq_req, irq_new, wake}, 0);
      rst_n = 1;
      @(negedge clk);

      // R3 write and read back
      sw_write(6'h16, 32'hA5A5_0000, 32'h0000_F0F0, 1, ill);
      sw_read(6'h16, d, ill);
      chk(d == 32'hA5A5_F0F0 && !ill, "R3 overwrite readback", d, 32'hA5A5_F0F0);
      sw_read(6'h20, d, ill);
      chk(d == 0, "R3 other address reads zero", d, 0);
      // R1 set
      sw_write(6'h14, 32'h0F00_0000, 32'h0000_0001, 1, ill);
      sw_read(6'h16, d, ill);
      chk(d == 32'hAFA5_F0F1, "R1 set ORs xor value", d, 32'hAFA5_F0F1);
      // R2 clear
      sw_write(6'h15, 32'hFFFF_0000, 32'h0F0F_0001, 1, ill);
      sw_read(6'h16, d, ill);
      chk(d == 32'h0F05_F0F0, "R2 clear bits", d, 32'h0F05_F0F0);
      // R4 user writes ignored and illegal
      sw_write(6'h16, 32'h1234_5678, 0, 0, ill);
      chk(ill == 1, "R4 user write illegal", ill, 1);
      sw_read(6'h16, d, ill);
      chk(d == 32'h0F05_F0F0 && !ill, "R4 user write ignored, user read legal", d, 32'h0F05_F0F0);
      sw_write(6'h15, 32'hFFFF_FFFF, 0, 0, ill);
      sw_read(6'h16, d, ill);
      chk(d == 32'h0F05_F0F0, "R4 user clear ignored", d, 32'h0F05_F0F0);
      supervisor = 1;
      sw_read(6'h14, d, ill);
      chk(ill == 1, "R4 read of set address illegal", ill, 1);
      sw_read(6'h15, d, ill);
      chk(ill == 1, "R4 read of clear address illegal", ill, 1);
      supervisor = 0;

      // R6/R7 soft bit sweep
      for (int k = 0; k < 32; k++) begin
         sw_write(6'h16, 32'h1 << k, 32'h0, 1, ill);
         @(negedge clk);
         e = exp_code(16'h0, 32'h1 << k);
         chk(trap_code == e && irq_req == (e != 0), $sformatf("R6 soft bit %0d", k), trap_code, e);
      end
      sw_write(6'h16, 0, 0, 1, ill);
      @(negedge clk);
      chk(trap_code == 0 && !irq_req, "R11 idle after soft clear", trap_code, 0);

      // R7 ext pair sweep, R12 wake, R11 retract
      for (int i = 1; i < 16; i++) begin
         for (int j = 1; j < 16; j++) begin
            ext_lvl = (16'h1 << i) | (16'h1 << j);
            @(negedge clk);
            e = 8'h40 | 8'((i > j) ? i : j);
            chk(trap_code == e && irq_req, $sformatf("R7 ext pair %0d,%0d", i, j), trap_code, e);
            chk(irq_new == 1, "R10 new code pulse", irq_new, 1);
            chk(wake == 1, "R12 wake on rise", wake, 1);
            ext_lvl = 0;
            @(negedge clk);
            chk(trap_code == 0 && !irq_req, "R11 retract", trap_code, 0);
         end
      end

      // R10 pulse only on change
      ext_lvl = 16'h0008;
      @(negedge clk);
      chk(irq_new && trap_code == 8'h43, "R10 first raise", trap_code, 8'h43);
      @(negedge clk);
      chk(!irq_new && !wake, "R10 no pulse when held, R12 no wake", {irq_new, wake}, 0);
      ext_lvl = 16'h000C;
      @(negedge clk);
      chk(!irq_new && trap_code == 8'h43, "R10 lower level no pulse", trap_code, 8'h43);
      chk(wake == 1, "R12 wake on added line", wake, 1);
      ext_lvl = 16'h020C;
      @(negedge clk);
      chk(irq_new && trap_code == 8'h49, "R10 higher level pulse", trap_code, 8'h49);
      ext_lvl = 0;
      @(negedge clk);

      // R8 level 0
      ext_lvl = 16'h0001;
      @(negedge clk);
      chk(trap_code == 0 && !irq_req, "R8 level 0 alone no request", trap_code, 0);
      ext_lvl = 16'h0021;
      @(negedge clk);
      chk(trap_code == 8'h45, "R8 level 5 raised", trap_code, 8'h45);
      ext_lvl = 16'h0001;
      @(negedge clk);
      @(negedge clk);
      chk(trap_code == 8'h45 && irq_req, "R8 level 0 only holds code", trap_code, 8'h45);
      ext_lvl = 0;
      @(negedge clk);
      chk(trap_code == 0, "R11 clear after level 0 drop", trap_code, 0);

      // R9 other trap blocks
      other_trap_pend = 1;
      ext_lvl = 16'h0080;
      repeat (2) @(negedge clk);
      chk(trap_code == 0 && !irq_req, "R9 update blocked", trap_code, 0);
      other_trap_pend = 0;
      @(negedge clk);
      chk(trap_code == 8'h47 && irq_new, "R9 update after release", trap_code, 8'h47);
      other_trap_pend = 1;
      ext_lvl = 0;
      repeat (2) @(negedge clk);
      chk(trap_code == 8'h47 && irq_req, "R9 clear blocked", trap_code, 8'h47);
      other_trap_pend = 0;
      @(negedge clk);
      chk(trap_code == 0 && !irq_req, "R11 clear after release", trap_code, 0);

      // R5 timer
      @(negedge clk);
      timer_match = 1;
      @(negedge clk);
      timer_match = 0;
      sw_read(6'h16, d, ill);
      chk(d == 32'h1, "R5 timer sets bit 0", d, 1);
      @(negedge clk);
      chk(trap_code == 8'h4E, "R5 timer bit requests level 14", trap_code, 8'h4E);
      @(negedge clk);
      reg_wr_en = 1; reg_addr = 6'h15; reg_opa = 32'h1; reg_opb = 0;
      supervisor = 1; timer_match = 1;
      @(negedge clk);
      reg_wr_en = 0; supervisor = 0; timer_match = 0;
      sw_read(6'h16, d, ill);
      chk(d == 32'h1, "R5 timer wins over same-cycle clear", d, 1);
      sw_write(6'h15, 32'h1, 0, 1, ill);
      sw_read(6'h16, d, ill);
      chk(d == 0, "R2 clear of timer bit", d, 0);
      @(negedge clk);
      chk(trap_code == 0, "R11 clear after timer cleared", trap_code, 0);

      finish_run();
   end
endmodule